// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one host request into the complete bus sequence that a raw NAND flash device expects for a command. A request carries an opcode, an optional column address, an optional page address, a flag for a 16-bit device and a flag for three-byte row addressing. The sequencer sends the command latch cycles and then the address latch cycles, one write strobe per byte. It manages chip enable and then waits the post-command time that the opcode calls for. When the sequence ends it raises a one-cycle done pulse.

For program setup (sequential input), a pointer command is chosen from the column and sent first, and the column is rebased to match. For a 16-bit part the column is halved, except for opcodes that always use byte addressing. For page reads, chip enable is held low from just before the second row byte through the whole busy period. That busy wait is bounded, and a timeout flag reports a read that never became ready. Reset and unlisted opcodes wait for ready with no limit. Program, erase, sequential input and status finish as soon as their bytes are out.

All bus timing is given in clock cycles by parameters: strobe low and high time, the write-to-busy delay, the poll interval (one microsecond, which is also the hold after address latch drops) and the poll limit.

Top module: `nand_cmd_seq`

## Requirements
- R1: For opcode 0x80 (sequential input), a pointer command is sent before 0x80. If the column is PAGE_BYTES or more, the pointer is 0x50 and PAGE_BYTES is subtracted from the column. If the column is below 256, or absent, the pointer is 0x00. Otherwise the pointer is 0x01 and 256 is subtracted.
- R2: Command bytes are strobed with CLE high and ALE low. Address bytes are strobed with ALE high and CLE low. CLE and ALE are never both high. No address byte is sent when neither a column nor a page is given.
- R3: With the 16-bit flag set, the column byte is the column shifted right by one. Opcodes 0x90, 0xEC, 0xEE and 0xEF keep the column unshifted. On a 16-bit write the upper I/O byte is zero.
- R4: Address bytes go out in this order: the column byte, then page bits 7:0, then page bits 15:8. When three-byte rows are enabled, a last byte follows with page bits 19:16 in its low nibble and zero in its high nibble.
- R5: For opcodes 0x00, 0x01 and 0x50 with a page address, chip enable stays low from the start of the second row byte until the done pulse. It is high in the done cycle.
- R6: In that read case, after TWB_CYC cycles ready is sampled, and then sampled again every POLL_CYC cycles, up to MAX_POLLS more times. If it is never seen high, done comes with timeout set. The timeout flag is cleared when the next request is accepted.
- R7: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 finish without sampling ready.
- R8: Opcode 0xFF, any other opcode, and a read with no page all wait TWB_CYC cycles and then wait for ready with no limit.
- R9: Ready is bit 0 of dev_stat. The other bits have no effect.
- R10: After the last address byte, ALE is low and no strobe occurs for at least POLL_CYC cycles before the wait or the done pulse.
- R11: Each byte is exactly one nWE low pulse. The I/O value does not change at the rising edge, and chip enable is low while nWE is low.
- R12: After reset, the block is idle with nWE, nCE high and CLE, ALE low. A request is taken only when idle is high, and requests made while busy are ignored. done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_opcode | input | 8 | Command opcode |
| req_has_col | input | 1 | Column address present |
| req_col | input | COL_W | Column address |
| req_has_page | input | 1 | Page address present |
| req_page | input | ROW_W | Page address |
| req_bus16 | input | 1 | Device has a 16-bit bus |
| req_row3 | input | 1 | Three-byte row addressing |
| dev_stat | input | STAT_W | Device status, bit 0 is ready |
| idle | output | 1 | Ready to take a request |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_io | output | IO_W | Data bus to the device |
| done | output | 1 | Sequence finished pulse |
| timeout | output | 1 | Bounded read wait expired |

## Verification
The request patterns cover sequential input with a column in each of the three pointer ranges (low half, upper half, spare area). The same case is repeated on a 16-bit bus, and contrasted with an ID read whose column must not be halved. This separates the rebasing from the scaling. A page read with three-byte rows and a busy status that has all upper bits set checks the row byte order and the held chip enable, and shows that only bit 0 counts as ready. A read that never becomes ready checks the poll limit and the length of the wait. An erase with a page, a status command with no address, and a reset that stays busy separate the three wait classes: no wait, bounded wait and unbounded wait. The busy reset also shows that a request made mid-sequence is dropped.

// File: rtl/nfseq_pkg.sv
`timescale 1ns/1ps
package nfseq_pkg;

    localparam logic [7:0] OP_READ0   = 8'h00;
    localparam logic [7:0] OP_READ1   = 8'h01;
    localparam logic [7:0] OP_READOOB = 8'h50;
    localparam logic [7:0] OP_SEQIN   = 8'h80;
    localparam logic [7:0] OP_PROG    = 8'h10;
    localparam logic [7:0] OP_ERASE1  = 8'h60;
    localparam logic [7:0] OP_ERASE2  = 8'hD0;
    localparam logic [7:0] OP_STATUS  = 8'h70;
    localparam logic [7:0] OP_RESET   = 8'hFF;
    localparam logic [7:0] OP_READID  = 8'h90;
    localparam logic [7:0] OP_PARAM   = 8'hEC;
    localparam logic [7:0] OP_GETFEAT = 8'hEE;
    localparam logic [7:0] OP_SETFEAT = 8'hEF;

    // two commands, one column byte, up to three row bytes
    localparam int SLOTS = 6;
    localparam int SLOT_W = $clog2(SLOTS + 1);

    typedef enum logic [1:0] {
        WAIT_NONE,
        WAIT_BOUNDED,
        WAIT_OPEN
    } wait_kind_e;

    typedef struct packed {
        logic       is_addr;
        logic       force_ce;
        logic [7:0] data;
    } bus_item_t;

    typedef struct packed {
        bus_item_t [SLOTS-1:0] items;
        logic [SLOT_W-1:0]     count;
        logic                  has_addr;
        wait_kind_e            wait_kind;
    } cmd_plan_t;

    function automatic logic is_page_read(input logic [7:0] op);
        return (op == OP_READ0) || (op == OP_READ1) || (op == OP_READOOB);
    endfunction

    function automatic logic is_byte_addr_op(input logic [7:0] op);
        return (op == OP_READID) || (op == OP_PARAM) ||
               (op == OP_GETFEAT) || (op == OP_SETFEAT);
    endfunction

    function automatic wait_kind_e wait_class(input logic [7:0] op, input logic has_page);
        if ((op == OP_PROG) || (op == OP_ERASE1) || (op == OP_ERASE2) ||
            (op == OP_SEQIN) || (op == OP_STATUS))
            return WAIT_NONE;
        if (is_page_read(op))
            return has_page ? WAIT_BOUNDED : WAIT_OPEN;
        return WAIT_OPEN;
    endfunction

endpackage

// File: rtl/nfseq_plan.sv
`timescale 1ns/1ps
module nfseq_plan
    import nfseq_pkg::*;
#(
    parameter int PAGE_BYTES = 512,
    parameter int COL_W      = 12,
    parameter int ROW_W      = 20
) (
    input  logic [7:0]       op,
    input  logic             has_col,
    input  logic [COL_W-1:0] col,
    input  logic             has_page,
    input  logic [ROW_W-1:0] page,
    input  logic             bus16,
    input  logic             row3,
    output cmd_plan_t        plan
);
    localparam logic [COL_W-1:0] PAGE_C = COL_W'(PAGE_BYTES);
    localparam logic [COL_W-1:0] HALF_C = COL_W'(256);
    localparam int HI_W = ROW_W - 16;

    logic [COL_W-1:0]  c_adj;
    logic [7:0]        pre_op;
    logic [SLOT_W-1:0] n;

    always_comb begin
        plan   = '0;
        n      = '0;
        c_adj  = col;
        pre_op = OP_READ0;

        // pointer command picked from the column for sequential input
        if ((op == OP_SEQIN) && has_col) begin
            if (col >= PAGE_C) begin
                pre_op = OP_READOOB;
                c_adj  = col - PAGE_C;
            end else if (col < HALF_C) begin
                pre_op = OP_READ0;
            end else begin
                pre_op = OP_READ1;
                c_adj  = col - HALF_C;
            end
        end
        if (bus16 && !is_byte_addr_op(op))
            c_adj = c_adj >> 1;

        if (op == OP_SEQIN) begin
            plan.items[n] = '{is_addr: 1'b0, force_ce: 1'b0, data: pre_op};
            n = n + 1'b1;
        end
        plan.items[n] = '{is_addr: 1'b0, force_ce: 1'b0, data: op};
        n = n + 1'b1;

        if (has_col) begin
            plan.items[n] = '{is_addr: 1'b1, force_ce: 1'b0, data: c_adj[7:0]};
            n = n + 1'b1;
        end
        if (has_page) begin
            plan.items[n] = '{is_addr: 1'b1, force_ce: 1'b0, data: page[7:0]};
            n = n + 1'b1;
            plan.items[n] = '{is_addr: 1'b1, force_ce: is_page_read(op), data: page[15:8]};
            n = n + 1'b1;
            if (row3) begin
                plan.items[n] = '{is_addr: 1'b1, force_ce: 1'b0,
                                  data: 8'(page[ROW_W-1:ROW_W-HI_W])};
                n = n + 1'b1;
            end
        end
        plan.count     = n;
        plan.has_addr  = has_col || has_page;
        plan.wait_kind = wait_class(op, has_page);
    end
endmodule

// File: rtl/nfseq_wrcycle.sv
`timescale 1ns/1ps
module nfseq_wrcycle #(
    parameter int LOW_CYC  = 3,
    parameter int HIGH_CYC = 3,
    parameter int IO_W     = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [7:0]      din,
    output logic            we_n,
    output logic [IO_W-1:0] io,
    output logic            active,
    output logic            ack
);
    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;
    phase_e        ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            cnt  <= '0;
            we_n <= 1'b1;
            io   <= '0;
        end else begin
            case (ph)
                PH_IDLE: if (start) begin
                    io   <= IO_W'(din);
                    we_n <= 1'b0;
                    cnt  <= CW'(LOW_CYC - 1);
                    ph   <= PH_LOW;
                end
                PH_LOW: if (cnt == '0) begin
                    we_n <= 1'b1;
                    cnt  <= CW'(HIGH_CYC - 1);
                    ph   <= PH_HIGH;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_HIGH: if (cnt == '0) ph <= PH_IDLE;
                         else cnt <= cnt - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign active = (ph != PH_IDLE);
    assign ack    = (ph == PH_HIGH) && (cnt == '0);

    AST_IO_STABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> $stable(io)); // R11
endmodule

// File: rtl/nfseq_rdywait.sv
`timescale 1ns/1ps
module nfseq_rdywait #(
    parameter int TWB_CYC   = 20,
    parameter int POLL_CYC  = 200,
    parameter int MAX_POLLS = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bounded,
    input  logic ready,
    output logic fin,
    output logic expired
);
    localparam int TW = $clog2(TWB_CYC + 1);
    localparam int GW = $clog2(POLL_CYC + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    typedef enum logic [1:0] {W_IDLE, W_TWB, W_CHECK, W_GAP} wst_e;
    wst_e          st;
    logic [TW-1:0] twb_cnt;
    logic [GW-1:0] gap_cnt;
    logic [PW-1:0] polls;

    assign expired = (st == W_CHECK) && !ready && bounded && (polls == PW'(MAX_POLLS));
    assign fin     = (st == W_CHECK) && (ready || expired);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= W_IDLE;
            twb_cnt <= '0;
            gap_cnt <= '0;
            polls   <= '0;
        end else begin
            case (st)
                W_IDLE: if (start) begin
                    twb_cnt <= TW'(TWB_CYC - 1);
                    polls   <= '0;
                    st      <= W_TWB;
                end
                W_TWB: if (twb_cnt == '0) st <= W_CHECK;
                       else twb_cnt <= twb_cnt - 1'b1;
                W_CHECK: begin
                    if (fin) begin
                        st <= W_IDLE;
                    end else if (bounded) begin
                        polls   <= polls + 1'b1;
                        gap_cnt <= GW'(POLL_CYC - 2);
                        st      <= W_GAP;
                    end
                end
                W_GAP: if (gap_cnt == '0) st <= W_CHECK;
                       else gap_cnt <= gap_cnt - 1'b1;
                default: st <= W_IDLE;
            endcase
        end
    end

    AST_POLL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (st == W_GAP) |-> (polls <= PW'(MAX_POLLS))); // R6
    AST_CHECK_AFTER_TWB: assert property (@(posedge clk) disable iff (rst)
        ($past(st) == W_IDLE && st != W_IDLE) |-> (st == W_TWB)); // R8
endmodule

// File: rtl/nand_cmd_seq.sv
`timescale 1ns/1ps
module nand_cmd_seq
    import nfseq_pkg::*;
#(
    parameter int PAGE_BYTES  = 512,
    parameter int COL_W       = 12,
    parameter int ROW_W       = 20,
    parameter int IO_W        = 16,
    parameter int STAT_W      = 8,
    parameter int WE_LOW_CYC  = 3,
    parameter int WE_HIGH_CYC = 3,
    parameter int TWB_CYC     = 20,
    parameter int POLL_CYC    = 200,
    parameter int MAX_POLLS   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        req_opcode,
    input  logic              req_has_col,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_has_page,
    input  logic [ROW_W-1:0]  req_page,
    input  logic              req_bus16,
    input  logic              req_row3,
    input  logic [STAT_W-1:0] dev_stat,
    output logic              idle,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_ce_n,
    output logic              nand_we_n,
    output logic [IO_W-1:0]   nand_io,
    output logic              done,
    output logic              timeout
);
    localparam int HOLD_CYC = POLL_CYC;
    localparam int HW = $clog2(HOLD_CYC + 1);

    typedef enum logic [2:0] {S_IDLE, S_BUS, S_PULSE, S_HOLD, S_WAIT, S_FIN} seq_e;

    seq_e              st;
    cmd_plan_t         plan_in, plan_q;
    logic [SLOT_W-1:0] idx;
    logic [HW-1:0]     hold_cnt;
    logic              force_q, tmo_q;
    bus_item_t         cur;
    logic              cur_ok;
    logic              wr_start, wr_active, wr_ack;
    logic              rw_start, rw_fin, rw_expired;

    nfseq_plan #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .ROW_W(ROW_W)) u_plan (
        .op(req_opcode), .has_col(req_has_col), .col(req_col),
        .has_page(req_has_page), .page(req_page),
        .bus16(req_bus16), .row3(req_row3), .plan(plan_in)
    );

    always_comb begin
        cur = '0;
        for (int k = 0; k < SLOTS; k++)
            if (idx == SLOT_W'(k)) cur = plan_q.items[k];
    end

    assign cur_ok   = (idx < plan_q.count);
    assign wr_start = (st == S_BUS) && cur_ok;

    nfseq_wrcycle #(.LOW_CYC(WE_LOW_CYC), .HIGH_CYC(WE_HIGH_CYC), .IO_W(IO_W)) u_wr (
        .clk(clk), .rst(rst), .start(wr_start), .din(cur.data),
        .we_n(nand_we_n), .io(nand_io), .active(wr_active), .ack(wr_ack)
    );

    assign rw_start = (plan_q.wait_kind != WAIT_NONE) &&
                      (((st == S_HOLD) && (hold_cnt == '0)) ||
                       ((st == S_BUS) && !cur_ok && !plan_q.has_addr));

    nfseq_rdywait #(.TWB_CYC(TWB_CYC), .POLL_CYC(POLL_CYC), .MAX_POLLS(MAX_POLLS)) u_rw (
        .clk(clk), .rst(rst), .start(rw_start),
        .bounded(plan_q.wait_kind == WAIT_BOUNDED), .ready(dev_stat[0]),
        .fin(rw_fin), .expired(rw_expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            plan_q   <= '0;
            idx      <= '0;
            hold_cnt <= '0;
            force_q  <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (req_valid) begin
                    plan_q <= plan_in;
                    idx    <= '0;
                    tmo_q  <= 1'b0;
                    st     <= S_BUS;
                end
                S_BUS: begin
                    if (cur_ok) begin
                        if (cur.force_ce) force_q <= 1'b1;
                        st <= S_PULSE;
                    end else if (plan_q.has_addr) begin
                        hold_cnt <= HW'(HOLD_CYC - 1);
                        st       <= S_HOLD;
                    end else begin
                        st <= (plan_q.wait_kind == WAIT_NONE) ? S_FIN : S_WAIT;
                    end
                end
                S_PULSE: if (wr_ack) begin
                    idx <= idx + 1'b1;
                    st  <= S_BUS;
                end
                S_HOLD: begin
                    if (hold_cnt == '0)
                        st <= (plan_q.wait_kind == WAIT_NONE) ? S_FIN : S_WAIT;
                    else
                        hold_cnt <= hold_cnt - 1'b1;
                end
                S_WAIT: if (rw_fin) begin
                    tmo_q   <= rw_expired;
                    force_q <= 1'b0;
                    st      <= S_FIN;
                end
                S_FIN:   st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    assign idle      = (st == S_IDLE);
    assign done      = (st == S_FIN);
    assign timeout   = tmo_q;
    assign nand_cle  = ((st == S_BUS) || (st == S_PULSE)) && cur_ok && !cur.is_addr;
    assign nand_ale  = ((st == S_BUS) || (st == S_PULSE)) && cur_ok && cur.is_addr;
    assign nand_ce_n = !(force_q || wr_active);

    AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale)); // R2
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> !nand_ce_n); // R11
    AST_READ_WAIT_CE: assert property (@(posedge clk) disable iff (rst)
        (st == S_WAIT && plan_q.wait_kind == WAIT_BOUNDED) |-> !nand_ce_n); // R5
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD) |-> (!nand_ale && nand_we_n)); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle |-> (nand_we_n && nand_ce_n && !nand_cle && !nand_ale)); // R12
    AST_TIMEOUT_READ: assert property (@(posedge clk) disable iff (rst)
        (done && timeout) |-> (plan_q.wait_kind == WAIT_BOUNDED)); // R6
endmodule

// File: tb/nand_cmd_seq_bench.sv
`timescale 1ns/1ps
module nand_cmd_seq_bench;
    localparam int PAGE_BYTES = 512;
    localparam int COL_W = 12, ROW_W = 20, IO_W = 16, STAT_W = 8;
    localparam int WE_LOW = 2, WE_HIGH = 2, TWB = 4, POLL = 10, MAXP = 30;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [7:0] req_opcode = '0;
    logic req_has_col = 1'b0, req_has_page = 1'b0, req_bus16 = 1'b0, req_row3 = 1'b0;
    logic [COL_W-1:0] req_col = '0;
    logic [ROW_W-1:0] req_page = '0;
    logic [STAT_W-1:0] dev_stat = 8'h01;
    logic idle, nand_cle, nand_ale, nand_ce_n, nand_we_n, done, timeout;
    logic [IO_W-1:0] nand_io;

    nand_cmd_seq #(.PAGE_BYTES(PAGE_BYTES), .COL_W(COL_W), .ROW_W(ROW_W), .IO_W(IO_W),
                   .STAT_W(STAT_W), .WE_LOW_CYC(WE_LOW), .WE_HIGH_CYC(WE_HIGH),
                   .TWB_CYC(TWB), .POLL_CYC(POLL), .MAX_POLLS(MAXP)) u_nand_cmd_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_has_col(req_has_col), .req_col(req_col), .req_has_page(req_has_page),
        .req_page(req_page), .req_bus16(req_bus16), .req_row3(req_row3),
        .dev_stat(dev_stat), .idle(idle), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_io(nand_io),
        .done(done), .timeout(timeout)
    );

    typedef struct packed {
        logic        cle;
        logic        ale;
        logic [15:0] data;
        logic        mark;
    } exp_t;

    exp_t expq[$];
    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int rise_cyc = 0, done_cyc = 0, ce_hi = 0;
    bit done_seen = 0, armed = 0, finished = 0;
    logic prev_we = 1'b1;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // monitor: pops the scoreboard at every rising strobe edge
    always @(negedge clk) begin
        if (!rst) begin
            if (!prev_we && nand_we_n) begin
                rise_cyc = cyc;
                if (expq.size() == 0) begin
                    check(0, "R12", "unexpected bus write", int'(nand_io), 0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check({nand_cle, nand_ale, nand_io} == {e.cle, e.ale, e.data},
                          "R2/R4", "bus byte {cle,ale,io}",
                          int'({nand_cle, nand_ale, nand_io}), int'({e.cle, e.ale, e.data}));
                    if (e.mark) armed = 1;
                end
            end
            if (!nand_we_n && nand_ce_n)
                check(0, "R11", "ce_n high while we_n low", 1, 0);
            if (done) begin
                done_seen = 1;
                done_cyc  = cyc;
                armed     = 0;
            end else if (armed && nand_ce_n) begin
                ce_hi++;
            end
        end
        prev_we = nand_we_n;
    end

    task automatic push(input logic cle, input logic ale, input int d, input logic mark);
        exp_t e;
        e.cle = cle; e.ale = ale; e.data = 16'(d & 8'hFF); e.mark = mark;
        expq.push_back(e);
    endtask

    // expected bus bytes, written from the requirements
    task automatic build(input int op, input bit hc, input int col, input bit hp,
                         input int page, input bit b16, input bit r3);
        int c = col;
        bit rd = (op == 8'h00) || (op == 8'h01) || (op == 8'h50);
        if (op == 8'h80) begin // R1
            if (!hc)                   push(1, 0, 8'h00, 0);
            else if (c >= PAGE_BYTES) begin push(1, 0, 8'h50, 0); c -= PAGE_BYTES; end
            else if (c < 256)          push(1, 0, 8'h00, 0);
            else begin                 push(1, 0, 8'h01, 0); c -= 256; end
        end
        push(1, 0, op, 0);
        if (hc) begin // R3
            if (b16 && !(op == 8'h90 || op == 8'hEC || op == 8'hEE || op == 8'hEF)) c = c >> 1;
            push(0, 1, c, 0);
        end
        if (hp) begin // R4
            push(0, 1, page & 8'hFF, 0);
            push(0, 1, (page >> 8) & 8'hFF, rd);
            if (r3) push(0, 1, (page >> 16) & 4'hF, 0);
        end
    endtask

    task automatic issue(input int op, input bit hc, input int col, input bit hp,
                         input int page, input bit b16, input bit r3);
        build(op, hc, col, hp, page, b16, r3);
        done_seen = 0; armed = 0; ce_hi = 0;
        @(negedge clk);
        req_opcode = 8'(op); req_has_col = hc; req_col = COL_W'(col);
        req_has_page = hp; req_page = ROW_W'(page); req_bus16 = b16; req_row3 = r3;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit, input string req);
        int k = 0;
        while (!done_seen && k < limit) begin @(negedge clk); k++; end
        if (!done_seen) check(0, req, "done never pulsed", 0, 1);
        @(negedge clk);
        check(expq.size() == 0, req, "bytes left unsent", expq.size(), 0);
    endtask

    task automatic ce_released(input string req);
        check(nand_ce_n == 1'b1 && idle == 1'b1, req, "ce_n/idle after done",
              int'({nand_ce_n, idle}), 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish (actual hang, expected end)");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int el, raise;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check({idle, nand_we_n, nand_ce_n, nand_cle, nand_ale, done} == 6'b111000,
              "R12", "reset outputs", int'({idle, nand_we_n, nand_ce_n, nand_cle, nand_ale, done}), 6'b111000);

        // R1 low column, R7 no wait even while busy, R10 hold
        dev_stat = 8'h00;
        issue(8'h80, 1, 10, 1, 16'h1234, 0, 0);
        wait_done(400, "R1");
        el = done_cyc - rise_cyc;
        check(el >= POLL && el <= POLL + WE_HIGH + 4, "R10", "cycles last address to done", el, POLL + WE_HIGH + 1);
        ce_released("R7");

        // R1 upper half column
        issue(8'h80, 1, 300, 1, 16'h0007, 0, 0);
        wait_done(400, "R1");
        // R1 spare area column
        issue(8'h80, 1, 520, 0, 0, 0, 0);
        wait_done(400, "R1");
        // R1 absent column
        issue(8'h80, 0, 0, 1, 16'h0302, 0, 0);
        wait_done(400, "R1");
        // R3 halved column on 16-bit bus
        issue(8'h80, 1, 300, 0, 0, 1, 0);
        wait_done(400, "R3");

        // R3 byte-addressed opcode keeps column; R8 open wait finishes on ready
        dev_stat = 8'h01;
        issue(8'h90, 1, 8'h20, 0, 0, 1, 0);
        wait_done(400, "R3");
        check(timeout == 1'b0, "R8", "timeout after open wait", timeout, 0);

        // R4 R5 R9: page read, three-byte row, busy status with upper bits set
        dev_stat = 8'hFE;
        issue(8'h00, 1, 8'h40, 1, 20'h5ABCD, 1, 1);
        repeat (120) @(negedge clk);
        check(!done_seen, "R9", "done while bit 0 low", done_seen, 0);
        raise = cyc;
        dev_stat = 8'h01;
        wait_done(400, "R5");
        el = done_cyc - raise;
        check(el <= POLL + 4, "R6", "cycles ready to done", el, POLL);
        check(ce_hi == 0, "R5", "ce_n high cycles in forced window", ce_hi, 0);
        check(timeout == 1'b0, "R6", "timeout after ready", timeout, 0);
        ce_released("R5");

        // R6 read never ready
        dev_stat = 8'h00;
        issue(8'h01, 0, 0, 1, 16'h4321, 0, 0);
        wait_done(800, "R6");
        el = done_cyc - rise_cyc;
        check(el >= POLL + TWB + MAXP * POLL && el <= POLL + TWB + MAXP * POLL + 8,
              "R6", "cycles last address to timeout", el, POLL + TWB + MAXP * POLL + WE_HIGH + 2);
        check(timeout == 1'b1, "R6", "timeout flag", timeout, 1);
        check(ce_hi == 0, "R5", "ce_n high cycles in forced window", ce_hi, 0);

        // R7 R10 erase with page, busy device
        issue(8'h60, 0, 0, 1, 16'h0102, 0, 0);
        wait_done(400, "R7");
        check(timeout == 1'b0, "R6", "timeout cleared by new request", timeout, 0);
        el = done_cyc - rise_cyc;
        check(el >= POLL && el <= POLL + WE_HIGH + 4, "R10", "erase hold before done", el, POLL + WE_HIGH + 1);

        // R2 R7 status: no address, no wait
        issue(8'h70, 0, 0, 0, 0, 0, 0);
        wait_done(100, "R2");
        el = done_cyc - rise_cyc;
        check(el <= WE_HIGH + 4, "R7", "status command to done", el, WE_HIGH + 1);

        // R8 R12 reset waits without bound, extra request dropped
        issue(8'hFF, 0, 0, 0, 0, 0, 0);
        repeat (60) @(negedge clk);
        check(idle == 1'b0, "R12", "idle while sequence busy", idle, 0);
        req_opcode = 8'h70; req_has_col = 0; req_has_page = 0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (440) @(negedge clk);
        check(!done_seen, "R8", "done before ready on reset", done_seen, 0);
        raise = cyc;
        dev_stat = 8'h01;
        wait_done(100, "R8");
        el = done_cyc - raise;
        check(el <= 4, "R8", "cycles ready to done", el, 1);
        repeat (40) @(negedge clk);
        check(expq.size() == 0 && idle, "R12", "idle and no extra bytes", expq.size(), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule